// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block holds pending interrupt requests in a grid of priority levels. Each level owns a vector of sources. A second, one-bit-per-level register records which levels have any source set. Requests enter through post and clear commands, each addressed by a level and a source index. A clear-all command empties the whole grid at once.

A software request word sits beside the hardware levels. The block maps its bits and the pending hardware levels onto a single priority scale. The block's combinational logic finds the winning priority and a mask of every contributor, then compares the winner with the processor's current priority level. When the request is strictly higher, the block asserts a take signal and captures the priority and mask in a held slot marked valid. A later commit strobe moves the held pair to the status and ID outputs, which the trap logic reads. A separate pending flag tells the core that something is queued, but only while the two low bits of the program counter are zero.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A post with a level below 32 and an index below 64 sets that source bit. On the next clock edge it sets bit `level` of `lvl_summary`.
- R2: A clear drops only the addressed source bit. Bit `level` of `lvl_summary` goes to 0 only when no source of that level remains set.
- R3: `clr_all` zeroes every source bit and all of `lvl_summary` in one cycle. It overrides a post issued in the same cycle.
- R4: `lvl_pending` is 1 exactly when `lvl_summary` is nonzero and `pc_low` equals 2'b00.
- R5: Each set `sw_req` bit i, for i from 1 to 15, gives priority (i-1)+1 = i and sets `req_mask[i]`. Bit 0 and bits 16 to 31 of `sw_req` have no effect.
- R6: Each set `lvl_summary` bit i, for i from 16 to 31, gives priority i and sets `req_mask[i]`. The highest such level beats every software bit. Summary bits 0 to 15 do not enter `req_prio` or `req_mask`.
- R7: `take` is 1 exactly when `req_prio` is nonzero and strictly greater than `cur_ipl`. In all other cases it is 0.
- R8: At each clock edge where `take` is 1, the block captures `req_prio` and `req_mask` and sets `info_valid`.
- R9: A `commit` while `info_valid` is 1 copies the captured mask to `status_out` and the captured priority to `id_out`. It also clears `info_valid`, unless `take` is 1 in the same cycle. In that case the new pair is captured and `info_valid` stays 1.
- R10: A `commit` while `info_valid` is 0 leaves `status_out` and `id_out` unchanged. It gives a one-cycle `commit_err` pulse after the edge.
- R11: A post or clear whose level is 32 or more, or whose index is 64 or more, changes no state. It gives a one-cycle `cmd_err` pulse after the edge.
- R12: If a post and a clear address the same source bit in the same cycle, the post wins and the bit ends up set.
- R13: A synchronous active-high `rst` zeroes all registers: source bits, `lvl_summary`, the captured slot, `status_out`, `id_out` and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | Post command strobe |
| post_lvl | input | 6 | Level addressed by the post |
| post_idx | input | 7 | Source index addressed by the post |
| clr_en | input | 1 | Clear command strobe |
| clr_lvl | input | 6 | Level addressed by the clear |
| clr_idx | input | 7 | Source index addressed by the clear |
| clr_all | input | 1 | Empty all levels |
| pc_low | input | 2 | Two low bits of the current program counter |
| sw_req | input | 32 | Software request word |
| cur_ipl | input | 5 | Current processor priority level |
| commit | input | 1 | Copy the captured pair to the outputs |
| lvl_summary | output | 32 | One bit per level with any source set |
| lvl_pending | output | 1 | Summary nonzero and PC aligned |
| req_prio | output | 5 | Resolved priority |
| req_mask | output | 32 | Mask of contributing levels and software bits |
| take | output | 1 | Request beats the current level |
| info_valid | output | 1 | Captured pair waiting for commit |
| status_out | output | 32 | Committed mask |
| id_out | output | 5 | Committed priority |
| cmd_err | output | 1 | Out-of-range post or clear seen last cycle |
| commit_err | output | 1 | Commit with nothing captured seen last cycle |

## Verification
The assertions take the command fields as arbitrary values, out-of-range ones included. They assume only that `clr_all` is low whenever a post is expected to land, and that commit and take meet only in the overlap case R9 describes. The stimulus drives every input on the falling edge and raises `clr_all` only in dedicated steps. It holds `take` low before a plain commit by clearing the requests first. Out-of-range levels alias onto a real level when truncated, so a dropped high bit would show up in the summary.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NLVL   = 32,
  parameter int NSRC   = 64,
  parameter int SW_LO  = 1,
  parameter int SW_HI  = 15,
  parameter int EXT_LO = 16,
  parameter int EXT_HI = 31,
  localparam int PW = $clog2(NLVL),
  localparam int LW = PW + 1,
  localparam int SW = $clog2(NSRC),
  localparam int IW = SW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            post_en,
  input  logic [LW-1:0]   post_lvl,
  input  logic [IW-1:0]   post_idx,
  input  logic            clr_en,
  input  logic [LW-1:0]   clr_lvl,
  input  logic [IW-1:0]   clr_idx,
  input  logic            clr_all,
  input  logic [1:0]      pc_low,
  input  logic [NLVL-1:0] sw_req,
  input  logic [PW-1:0]   cur_ipl,
  input  logic            commit,
  output logic [NLVL-1:0] lvl_summary,
  output logic            lvl_pending,
  output logic [PW-1:0]   req_prio,
  output logic [NLVL-1:0] req_mask,
  output logic            take,
  output logic            info_valid,
  output logic [NLVL-1:0] status_out,
  output logic [PW-1:0]   id_out,
  output logic            cmd_err,
  output logic            commit_err
);

  wire post_ok = post_en && (post_lvl < LW'(NLVL)) && (post_idx < IW'(NSRC));
  wire clr_ok  = clr_en  && (clr_lvl  < LW'(NLVL)) && (clr_idx  < IW'(NSRC));
  wire bad_cmd = (post_en && !post_ok) || (clr_en && !clr_ok);

  logic [NSRC-1:0] one_post, one_clr;
  assign one_post = {{(NSRC-1){1'b0}}, 1'b1} << post_idx[SW-1:0];
  assign one_clr  = {{(NSRC-1){1'b0}}, 1'b1} << clr_idx[SW-1:0];

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    logic [NSRC-1:0] src_q, set_m, clr_m, src_nxt;
    logic            sb_q;
    assign set_m   = (post_ok && post_lvl == LW'(l)) ? one_post : '0;
    assign clr_m   = (clr_ok  && clr_lvl  == LW'(l)) ? one_clr  : '0;
    assign src_nxt = (src_q & ~clr_m) | set_m;
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        src_q <= '0;
        sb_q  <= 1'b0;
      end else begin
        src_q <= src_nxt;
        if (|set_m)
          sb_q <= 1'b1;
        else if ((|clr_m) && src_nxt == '0)
          sb_q <= 1'b0;
      end
    end
    assign lvl_summary[l] = sb_q;
  end

  assign lvl_pending = (|lvl_summary) && (pc_low == 2'b00);

  always_comb begin
    req_prio = '0;
    req_mask = '0;
    for (int i = SW_LO; i <= SW_HI; i++)
      if (sw_req[i]) begin
        req_prio    = PW'(i - SW_LO + 1);
        req_mask[i] = 1'b1;
      end
    for (int i = EXT_LO; i <= EXT_HI; i++)
      if (lvl_summary[i]) begin
        req_prio    = PW'(i);
        req_mask[i] = 1'b1;
      end
  end

  assign take = (req_prio != '0) && (req_prio > cur_ipl);

  logic [PW-1:0]   lat_prio;
  logic [NLVL-1:0] lat_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_prio   <= '0;
      lat_mask   <= '0;
      info_valid <= 1'b0;
      status_out <= '0;
      id_out     <= '0;
      cmd_err    <= 1'b0;
      commit_err <= 1'b0;
    end else begin
      cmd_err    <= bad_cmd;
      commit_err <= commit && !info_valid;
      if (commit && info_valid) begin
        status_out <= lat_mask;
        id_out     <= lat_prio;
      end
      if (take) begin
        lat_prio   <= req_prio;
        lat_mask   <= req_mask;
        info_valid <= 1'b1;
      end else if (commit) begin
        info_valid <= 1'b0;
      end
    end
  end

  // R1
  a_r1_post_sets_summary: assert property (@(posedge clk) disable iff (rst)
    (post_ok && !clr_all) |=> lvl_summary[$past(post_lvl[PW-1:0])]);
  // R3
  a_r3_clear_all_empties: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (lvl_summary == '0));
  // R7
  a_r7_take_has_source: assert property (@(posedge clk) disable iff (rst)
    take |-> (req_mask != '0));
  // R8
  a_r8_take_captures: assert property (@(posedge clk) disable iff (rst)
    take |=> info_valid);
  // R9
  a_r9_commit_drains: assert property (@(posedge clk) disable iff (rst)
    (commit && info_valid && !take) |=> !info_valid);
  // R10
  a_r10_idle_commit_holds: assert property (@(posedge clk) disable iff (rst)
    (commit && !info_valid) |=> ($stable(status_out) && $stable(id_out) && commit_err));
  // R11
  a_r11_bad_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
    (post_en && post_lvl >= LW'(NLVL) && !clr_en) |=> (cmd_err && $stable(lvl_summary)));
  // R4
  a_r4_pending_needs_alignment: assert property (@(posedge clk) disable iff (rst)
    (pc_low != 2'b00) |-> !lvl_pending);

endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        post_en = 0, clr_en = 0, clr_all = 0, commit = 0;
  logic [5:0]  post_lvl = 0, clr_lvl = 0;
  logic [6:0]  post_idx = 0, clr_idx = 0;
  logic [1:0]  pc_low = 0;
  logic [31:0] sw_req = 0;
  logic [4:0]  cur_ipl = 0;
  logic [31:0] lvl_summary, req_mask, status_out;
  logic        lvl_pending, take, info_valid, cmd_err, commit_err;
  logic [4:0]  req_prio, id_out;

  lvl_irq_ctrl u_dut (
    .clk(clk), .rst(rst),
    .post_en(post_en), .post_lvl(post_lvl), .post_idx(post_idx),
    .clr_en(clr_en), .clr_lvl(clr_lvl), .clr_idx(clr_idx), .clr_all(clr_all),
    .pc_low(pc_low), .sw_req(sw_req), .cur_ipl(cur_ipl), .commit(commit),
    .lvl_summary(lvl_summary), .lvl_pending(lvl_pending),
    .req_prio(req_prio), .req_mask(req_mask), .take(take),
    .info_valid(info_valid), .status_out(status_out), .id_out(id_out),
    .cmd_err(cmd_err), .commit_err(commit_err)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic post(input logic [5:0] l, input logic [6:0] i);
    post_en = 1; post_lvl = l; post_idx = i; tick; post_en = 0;
  endtask

  task automatic clr(input logic [5:0] l, input logic [6:0] i);
    clr_en = 1; clr_lvl = l; clr_idx = i; tick; clr_en = 0;
  endtask

  task automatic wipe;
    clr_all = 1; tick; clr_all = 0;
  endtask

  typedef struct packed {
    logic [31:0] sw;
    logic [5:0]  ext;
    logic [4:0]  ipl;
    logic [4:0]  prio;
    logic        tk;
  } vec_t;

  localparam vec_t TBL [0:8] = '{
    '{32'h0000_0000, 6'd0,  5'd0,  5'd0,  1'b0},
    '{32'h0000_0008, 6'd0,  5'd0,  5'd3,  1'b1},
    '{32'h0000_1008, 6'd0,  5'd5,  5'd12, 1'b1},
    '{32'h0000_1000, 6'd0,  5'd12, 5'd12, 1'b0},
    '{32'h0000_0001, 6'd0,  5'd0,  5'd0,  1'b0},
    '{32'h0010_0000, 6'd0,  5'd0,  5'd0,  1'b0},
    '{32'h0000_8000, 6'd18, 5'd17, 5'd18, 1'b1},
    '{32'h0000_0080, 6'd31, 5'd31, 5'd31, 1'b0},
    '{32'h0000_0000, 6'd5,  5'd0,  5'd0,  1'b0}
  };

  task automatic summary_line;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary_line;
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst = 0;
    tick;
    // R13 reset state
    chk("R13 summary", lvl_summary, 0);
    chk("R13 valid", info_valid, 0);
    chk("R13 status", status_out, 0);
    chk("R13 id", id_out, 0);
    chk("R13 errs", {cmd_err, commit_err}, 0);

    // R5 R6 R7 table walk
    for (int k = 0; k <= 8; k++) begin
      logic [31:0] em;
      wipe;
      if (TBL[k].ext != 0) post(TBL[k].ext, 7'd3);
      sw_req = TBL[k].sw; cur_ipl = TBL[k].ipl;
      #1;
      em = TBL[k].sw & 32'h0000_FFFE;
      if (TBL[k].ext >= 16) em[TBL[k].ext[4:0]] = 1'b1;
      chk("R5/R6 prio", req_prio, TBL[k].prio);
      chk("R5/R6 mask", req_mask, em);
      chk("R7 take", take, TBL[k].tk);
      tick;
    end
    sw_req = 0; cur_ipl = 0;
    wipe;

    // R1 R2 two-tier clear
    post(6'd20, 7'd1);
    chk("R1 summary set", lvl_summary, 32'h0010_0000);
    post(6'd20, 7'd63);
    clr(6'd20, 7'd1);
    chk("R2 summary kept", lvl_summary, 32'h0010_0000);
    clr(6'd20, 7'd63);
    chk("R2 summary cleared", lvl_summary, 0);

    // R4 pending gate
    post(6'd2, 7'd0);
    pc_low = 2'b10; #1;
    chk("R4 misaligned", lvl_pending, 0);
    pc_low = 2'b00; #1;
    chk("R4 aligned", lvl_pending, 1);
    wipe;
    chk("R4 empty", lvl_pending, 0);

    // R3 clear-all beats post
    post(6'd7, 7'd4);
    post_en = 1; post_lvl = 6'd9; post_idx = 7'd1; clr_all = 1; tick;
    post_en = 0; clr_all = 0;
    chk("R3 all zero", lvl_summary, 0);

    // R12 post beats clear
    post_en = 1; post_lvl = 6'd22; post_idx = 7'd5;
    clr_en = 1; clr_lvl = 6'd22; clr_idx = 7'd5; tick;
    post_en = 0; clr_en = 0;
    chk("R12 post wins", lvl_summary, 32'h0040_0000);
    clr(6'd22, 7'd5);
    chk("R12 bit was set", lvl_summary, 0);

    // R11 out of range
    post(6'd40, 7'd0);
    chk("R11 cmd_err pulse", cmd_err, 1);
    chk("R11 level ignored", lvl_summary, 0);
    tick;
    chk("R11 pulse ends", cmd_err, 0);
    post(6'd9, 7'd70);
    chk("R11 index ignored", lvl_summary, 0);
    chk("R11 cmd_err idx", cmd_err, 1);
    post(6'd9, 7'd2);
    clr(6'd9, 7'd66);
    chk("R11 bad clear ignored", lvl_summary, 32'h0000_0200);
    wipe;

    // R8 R9 R10 capture and commit
    sw_req = 32'h0000_0200; tick;
    chk("R8 valid", info_valid, 1);
    sw_req = 0; #1;
    chk("R8 take drops", take, 0);
    commit = 1; tick; commit = 0;
    chk("R9 status", status_out, 32'h0000_0200);
    chk("R9 id", id_out, 9);
    chk("R9 valid cleared", info_valid, 0);
    commit = 1; tick; commit = 0;
    chk("R10 commit_err", commit_err, 1);
    chk("R10 status held", status_out, 32'h0000_0200);
    chk("R10 id held", id_out, 9);
    tick;
    chk("R10 pulse ends", commit_err, 0);

    // R9 overlap of take and commit
    sw_req = 32'h0000_0010; tick;
    sw_req = 32'h0000_0040; commit = 1; tick; commit = 0;
    chk("R9 overlap id", id_out, 4);
    chk("R9 overlap valid", info_valid, 1);
    sw_req = 0; commit = 1; tick; commit = 0;
    chk("R9 second id", id_out, 6);
    chk("R9 second status", status_out, 32'h0000_0040);

    // R13 reset mid-run
    post(6'd30, 7'd0);
    rst = 1; tick; rst = 0; #1;
    chk("R13 summary after rst", lvl_summary, 0);
    chk("R13 id after rst", id_out, 0);

    done = 1;
    summary_line;
    $finish;
  end
endmodule